// File: doc/BRIEF.md
# Mixed-Signal Boundary-Scan Test Controller

This block is the complete digital side of the test logic for a small mixed-signal part. A four-wire serial test port steps a sixteen-state controller. Through that port the tester loads an 8-bit instruction and then scans a 14-bit boundary chain. The chain holds one 4-bit routing word for the analog test-bus interface, one 4-bit word for each of two analog pin modules, and one cell each for a digital input pin and a digital output pin.

The latched routing words leave the block unchanged to the analog switch network and the per-pin pattern decoders, which are not part of this block. Test-mode and probe-mode flags go out with them. Three instructions select the boundary chain: external test, probe and sample. The probe instruction keeps the digital pins transparent while the analog routing words take effect. Every other code selects a one-bit bypass path.

Top module: `mstap_ctrl`

## Requirements
- R1: On each rising TCK edge the controller follows the standard sixteen-state test-port sequence. Five consecutive cycles with TMS high reach the reset state from any state, and the synchronous `rst` input forces that state too. While the reset state holds, the instruction becomes bypass and all update latches clear to 0.
- R2: The instruction register is 8 bits wide and shifts LSB first. On capture it loads 0x01, so the first two bits shifted out are 1 and then 0.
- R3: Opcode 0x00 is external test, 0x01 is probe, 0x02 is sample and 0xFF is bypass. Any other code behaves as bypass. `test_mode` is high for external test and probe only, and `probe_mode` is high for probe only.
- R4: Under bypass (`bypass_sel` = 1) the data path between TDI and TDO is a single register that captures 0. A data scan then returns 0 followed by the input delayed by one bit, and the update latches keep their values.
- R5: The boundary chain holds 14 bits, indexed 13 (TDI end) down to 0 (TDO end). Bits 13..10 hold the bus-interface word, bits 9..6 the analog-input module word, bits 5..2 the analog-output module word, bit 1 the digital-input cell and bit 0 the digital-output cell. Each word is ordered D, C, B1, B2 with D at the high index, and `bus_ctl`/`apin_ctl` present D at bit 3. Bit 0 is shifted in first, so the pattern 0001_0000_0001_00 (written from bit 13 down) gives `bus_ctl` = 0001, `apin_ctl[3:0]` = 0000 and `apin_ctl[7:4]` = 0001.
- R6: On capture, each analog module's D bit loads its comparator input (`cmp_in[0]` goes to bit 9, `cmp_in[1]` to bit 5), and its C, B1 and B2 bits load 0. The bus-interface word loads 0000, bit 1 loads `pin_din` and bit 0 loads `core_dout`.
- R7: The update latches change only on the edge that leaves the data-update state while the chain is selected, or in reset. The latched outputs stay constant during capture and shift.
- R8: Under probe the boundary chain is selected and the digital cells are transparent: `pin_dout` follows `core_dout` and `core_din` follows `pin_din`.
- R9: Under external test, `pin_dout` is the latched bit 0 and `core_din` is the latched bit 1. Changes on `core_dout` and `pin_din` have no effect on them.
- R10: Under sample and bypass the digital cells are transparent and `test_mode` is low.
- R11: TDO and `tdo_en` change on the falling TCK edge. `tdo_en` is high only while the controller is in the shift-instruction or shift-data state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, valid when tdo_en is high |
| tdo_en | output | 1 | TDO drive enable (high only in shift states) |
| cmp_in | input | 2 | Pin comparator results, bit 0 analog input pin, bit 1 analog output pin |
| pin_din | input | 1 | Value at the digital input pin |
| core_dout | input | 1 | Digital value the core drives toward its output pin |
| core_din | output | 1 | Digital value delivered to the core |
| pin_dout | output | 1 | Digital value driven to the output pin |
| bus_ctl | output | 4 | Latched bus-interface routing word, D at bit 3 |
| apin_ctl | output | 8 | Latched analog pin words, input module at 3:0, output module at 7:4 |
| test_mode | output | 1 | High under external test and probe |
| probe_mode | output | 1 | High under probe |
| bypass_sel | output | 1 | High when the bypass path is selected |

## Verification
A wrong controller state first shows on `tdo_en`. That flag goes high or stays low on the falling edge one half-cycle after the bad transition. The misstep then becomes visible as a shifted capture pattern over the following scan. A fault in the capture mapping or the chain order appears in the scan-out bits in the same scan, at the bit position of the wrong cell. A fault in the update path or the instruction decode does not show until the latched words, mode flags or digital mux outputs are read one cycle after the update edge. External-test and probe patterns therefore get their own checks on those ports.

// File: rtl/mstap_pkg.sv
package mstap_pkg;

  localparam int IR_W = 8;

  localparam logic [IR_W-1:0] OP_EXTEST = 8'h00;
  localparam logic [IR_W-1:0] OP_PROBE  = 8'h01;
  localparam logic [IR_W-1:0] OP_SAMPLE = 8'h02;
  localparam logic [IR_W-1:0] OP_BYPASS = 8'hFF;
  localparam logic [IR_W-1:0] IR_CAPVAL = 8'h01;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef struct packed {
    logic sel_bsr;
    logic test_mode;
    logic probe;
    logic extest;
    logic bypass;
  } instr_dec_t;

  function automatic instr_dec_t decode_op(input logic [IR_W-1:0] op);
    instr_dec_t d;
    d = '0;
    unique case (op)
      OP_EXTEST: begin d.sel_bsr = 1'b1; d.test_mode = 1'b1; d.extest = 1'b1; end
      OP_PROBE:  begin d.sel_bsr = 1'b1; d.test_mode = 1'b1; d.probe = 1'b1; end
      OP_SAMPLE: d.sel_bsr = 1'b1;
      default:   d.bypass = 1'b1;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/mstap_fsm.sv
module mstap_fsm
  import mstap_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e nxt;

  always_comb begin
    unique case (state)
      ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PA_DR;
      ST_PA_DR:  nxt = tms ? ST_EX2_DR : ST_PA_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PA_IR;
      ST_PA_IR:  nxt = tms ? ST_EX2_IR : ST_PA_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_RTI;
      default:   nxt = ST_TLR;
    endcase
  end

  always_ff @(posedge tck) begin
    if (rst) state <= ST_TLR;
    else     state <= nxt;
  end

endmodule

// File: rtl/mstap_ir.sv
module mstap_ir
  import mstap_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  logic       tdi,
  input  tap_state_e state,
  output logic       ir_so,
  output instr_dec_t dec
);

  logic [IR_W-1:0] ir_sr;
  logic [IR_W-1:0] ir_q;

  always_ff @(posedge tck) begin
    if (rst || state == ST_TLR) begin
      ir_sr <= IR_CAPVAL;
      ir_q  <= OP_BYPASS;
    end else begin
      unique case (state)
        ST_CAP_IR: ir_sr <= IR_CAPVAL;
        ST_SH_IR:  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        ST_UPD_IR: ir_q  <= ir_sr;
        default:   ;
      endcase
    end
  end

  assign ir_so = ir_sr[0];
  assign dec   = decode_op(ir_q);

endmodule

// File: rtl/mstap_bsr.sv
module mstap_bsr
  import mstap_pkg::*;
#(
  parameter int WORD_W = 4,
  parameter int N_APIN = 2
) (
  input  logic                     tck,
  input  logic                     rst,
  input  logic                     tdi,
  input  tap_state_e               state,
  input  logic                     sel,
  input  logic [N_APIN-1:0]        cmp_in,
  input  logic                     pin_din,
  input  logic                     core_dout,
  output logic                     so,
  output logic [WORD_W-1:0]        bus_ctl,
  output logic [N_APIN*WORD_W-1:0] apin_ctl,
  output logic                     din_upd,
  output logic                     dout_upd
);

  localparam int LEN = WORD_W * (N_APIN + 1) + 2;

  logic [LEN-1:0] cap_vec;
  logic [LEN-1:0] sr;
  logic [LEN-1:0] upd;

  assign cap_vec[LEN-1 -: WORD_W] = '0;
  assign cap_vec[1] = pin_din;
  assign cap_vec[0] = core_dout;

  for (genvar k = 0; k < N_APIN; k++) begin : g_apin
    localparam int BASE = LEN - WORD_W - (k + 1) * WORD_W;
    assign cap_vec[BASE +: WORD_W]   = {cmp_in[k], {(WORD_W-1){1'b0}}};
    assign apin_ctl[k*WORD_W +: WORD_W] = upd[BASE +: WORD_W];
  end

  always_ff @(posedge tck) begin
    if (rst || state == ST_TLR) begin
      sr  <= '0;
      upd <= '0;
    end else if (sel) begin
      unique case (state)
        ST_CAP_DR: sr  <= cap_vec;
        ST_SH_DR:  sr  <= {tdi, sr[LEN-1:1]};
        ST_UPD_DR: upd <= sr;
        default:   ;
      endcase
    end
  end

  assign so       = sr[0];
  assign bus_ctl  = upd[LEN-1 -: WORD_W];
  assign din_upd  = upd[1];
  assign dout_upd = upd[0];

endmodule

// File: rtl/mstap_ctrl.sv
module mstap_ctrl
  import mstap_pkg::*;
#(
  parameter int WORD_W = 4,
  parameter int N_APIN = 2
) (
  input  logic                     tck,
  input  logic                     rst,
  input  logic                     tms,
  input  logic                     tdi,
  output logic                     tdo,
  output logic                     tdo_en,
  input  logic [N_APIN-1:0]        cmp_in,
  input  logic                     pin_din,
  input  logic                     core_dout,
  output logic                     core_din,
  output logic                     pin_dout,
  output logic [WORD_W-1:0]        bus_ctl,
  output logic [N_APIN*WORD_W-1:0] apin_ctl,
  output logic                     test_mode,
  output logic                     probe_mode,
  output logic                     bypass_sel
);

  tap_state_e state;
  instr_dec_t dec;
  logic       ir_so;
  logic       bsr_so;
  logic       byp_q;
  logic       din_upd;
  logic       dout_upd;

  mstap_fsm u_fsm (
    .tck   (tck),
    .rst   (rst),
    .tms   (tms),
    .state (state)
  );

  mstap_ir u_ir (
    .tck   (tck),
    .rst   (rst),
    .tdi   (tdi),
    .state (state),
    .ir_so (ir_so),
    .dec   (dec)
  );

  mstap_bsr #(.WORD_W(WORD_W), .N_APIN(N_APIN)) u_bsr (
    .tck       (tck),
    .rst       (rst),
    .tdi       (tdi),
    .state     (state),
    .sel       (dec.sel_bsr),
    .cmp_in    (cmp_in),
    .pin_din   (pin_din),
    .core_dout (core_dout),
    .so        (bsr_so),
    .bus_ctl   (bus_ctl),
    .apin_ctl  (apin_ctl),
    .din_upd   (din_upd),
    .dout_upd  (dout_upd)
  );

  always_ff @(posedge tck) begin
    if (rst) byp_q <= 1'b0;
    else if (state == ST_CAP_DR) byp_q <= 1'b0;
    else if (state == ST_SH_DR)  byp_q <= tdi;
  end

  always_ff @(negedge tck) begin
    if (rst) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= (state == ST_SH_IR) || (state == ST_SH_DR);
      if (state == ST_SH_IR) tdo <= ir_so;
      else                   tdo <= dec.sel_bsr ? bsr_so : byp_q;
    end
  end

  assign test_mode  = dec.test_mode;
  assign probe_mode = dec.probe;
  assign bypass_sel = dec.bypass;
  assign pin_dout   = dec.extest ? dout_upd : core_dout;
  assign core_din   = dec.extest ? din_upd  : pin_din;

endmodule

// File: rtl/mstap_ctrl_chk.sv
module mstap_ctrl_chk
  import mstap_pkg::*;
#(
  parameter int WORD_W = 4,
  parameter int N_APIN = 2
) (
  input logic                     tck,
  input logic                     rst,
  input logic                     tms,
  input tap_state_e               state,
  input logic                     tdo_en,
  input logic [WORD_W-1:0]        bus_ctl,
  input logic [N_APIN*WORD_W-1:0] apin_ctl,
  input logic                     test_mode,
  input logic                     probe_mode,
  input logic                     bypass_sel,
  input logic                     pin_dout,
  input logic                     core_dout,
  input logic                     core_din,
  input logic                     pin_din
);

  p_five_ones_r1: assert property (@(posedge tck) disable iff (rst)
    ($past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4) && $past(tms, 5))
      |-> state == ST_TLR);

  p_reset_clears_r1: assert property (@(posedge tck) disable iff (rst)
    state == ST_TLR |=> (bus_ctl == '0 && apin_ctl == '0 && bypass_sel));

  p_mode_excl_r3: assert property (@(posedge tck) disable iff (rst)
    (test_mode |-> !bypass_sel) and (probe_mode |-> test_mode));

  p_latch_hold_r7: assert property (@(posedge tck) disable iff (rst)
    (state != ST_UPD_DR && state != ST_TLR) |=> ($stable(bus_ctl) && $stable(apin_ctl)));

  p_transparent_r8: assert property (@(posedge tck) disable iff (rst)
    (!test_mode || probe_mode) |-> (pin_dout == core_dout && core_din == pin_din));

  p_tdo_en_r11: assert property (@(posedge tck) disable iff (rst)
    tdo_en == (state == ST_SH_IR || state == ST_SH_DR));

endmodule

bind mstap_ctrl mstap_ctrl_chk #(.WORD_W(WORD_W), .N_APIN(N_APIN)) u_chk (
  .tck        (tck),
  .rst        (rst),
  .tms        (tms),
  .state      (state),
  .tdo_en     (tdo_en),
  .bus_ctl    (bus_ctl),
  .apin_ctl   (apin_ctl),
  .test_mode  (test_mode),
  .probe_mode (probe_mode),
  .bypass_sel (bypass_sel),
  .pin_dout   (pin_dout),
  .core_dout  (core_dout),
  .core_din   (core_din),
  .pin_din    (pin_din)
);

// File: tb/tb_mstap_ctrl.sv
module tb_mstap_ctrl;

  logic       tck = 1'b0;
  logic       rst = 1'b1;
  logic       tms = 1'b1;
  logic       tdi = 1'b0;
  logic       tdo, tdo_en;
  logic [1:0] cmp_in = 2'b00;
  logic       pin_din = 1'b0;
  logic       core_dout = 1'b0;
  logic       core_din, pin_dout;
  logic [3:0] bus_ctl;
  logic [7:0] apin_ctl;
  logic       test_mode, probe_mode, bypass_sel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  mstap_ctrl dut (
    .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
    .cmp_in(cmp_in), .pin_din(pin_din), .core_dout(core_dout),
    .core_din(core_din), .pin_dout(pin_dout), .bus_ctl(bus_ctl),
    .apin_ctl(apin_ctl), .test_mode(test_mode), .probe_mode(probe_mode),
    .bypass_sel(bypass_sel)
  );

  always #4 tck = ~tck;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d, output logic so, output logic soen);
    @(negedge tck);
    #1 tms = m; tdi = d;
    #1 so = tdo; soen = tdo_en;
    @(posedge tck);
  endtask

  task automatic shift_ir(input logic [7:0] v, output logic [7:0] cap);
    logic s, e;
    tick(1, 0, s, e); tick(1, 0, s, e); tick(0, 0, s, e); tick(0, 0, s, e);
    for (int i = 0; i < 8; i++) begin
      tick(i == 7, v[i], s, e);
      cap[i] = s;
      check("R11 tdo_en in shift-IR", e, 1);
    end
    tick(1, 0, s, e); tick(0, 0, s, e);
    #1;
  endtask

  task automatic scan_dr(input logic [13:0] v, output logic [13:0] cap);
    logic s, e;
    logic [3:0] b0;
    logic [7:0] a0;
    bit stable;
    stable = 1;
    tick(1, 0, s, e); tick(0, 0, s, e);
    b0 = bus_ctl; a0 = apin_ctl;
    tick(0, 0, s, e);
    check("R11 tdo_en low in capture", e, 0);
    for (int i = 0; i < 14; i++) begin
      tick(i == 13, v[i], s, e);
      cap[i] = s;
      if (!e) stable = 0;
      if (bus_ctl !== b0 || apin_ctl !== a0) stable = 0;
    end
    check("R7/R11 latches stable and tdo_en high during shift", stable, 1);
    tick(1, 0, s, e); tick(0, 0, s, e);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge tck);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0]  ic;
    logic [13:0] dc, pat, exp;
    logic s, e;
    repeat (3) @(posedge tck);
    @(negedge tck); #1 rst = 0; tms = 0;
    @(posedge tck); #1;
    // R1 reset state
    check("R1 reset bus_ctl", bus_ctl, 0);
    check("R1 reset apin_ctl", apin_ctl, 0);
    check("R1 reset bypass_sel", bypass_sel, 1);
    check("R3 reset test_mode", test_mode, 0);
    tick(0, 0, s, e);
    check("R11 tdo_en idle", e, 0);

    // R2 instruction capture, R4 bypass
    shift_ir(8'hFF, ic);
    check("R2 IR capture", ic, 8'h01);
    check("R4 bypass_sel", bypass_sel, 1);
    scan_dr(14'h2A5B, dc);
    check("R4 bypass scan", dc, {13'h2A5B & 13'h1FFF, 1'b0});
    check("R4 latches untouched", {bus_ctl, apin_ctl}, 0);

    // R6/R5/R10 near-exhaustive sample sweep
    shift_ir(8'h02, ic);
    check("R10 sample test_mode", test_mode, 0);
    for (int v = 0; v < 16; v++) begin
      cmp_in = v[3:2]; pin_din = v[1]; core_dout = v[0];
      pat = {v[3:0], ~v[3:0], v[3:0] ^ 4'h9, v[1:0]};
      exp = {4'b0, v[2], 3'b0, v[3], 3'b0, v[1], v[0]};
      scan_dr(pat, dc);
      check("R6 capture pattern", dc, exp);
      check("R5 bus word", bus_ctl, pat[13:10]);
      check("R5 pin words", apin_ctl, {pat[5:2], pat[9:6]});
      check("R10 sample transparent", {core_din, pin_dout}, {v[1], v[0]});
    end

    // R8 probe with reference routing pattern
    shift_ir(8'h01, ic);
    scan_dr(14'b0001_0000_0001_00, dc);
    check("R5 probe bus word", bus_ctl, 4'b0001);
    check("R5 probe pin words", apin_ctl, 8'h10);
    check("R8 probe modes", {test_mode, probe_mode, bypass_sel}, 3'b110);
    for (int v = 0; v < 4; v++) begin
      pin_din = v[1]; core_dout = v[0]; #2;
      check("R8 probe transparent", {core_din, pin_dout}, {v[1], v[0]});
    end

    // R9 external test
    shift_ir(8'h00, ic);
    check("R9 extest modes", {test_mode, probe_mode}, 2'b10);
    scan_dr(14'b1000_0100_0010_10, dc);
    for (int v = 0; v < 4; v++) begin
      pin_din = v[1]; core_dout = v[0]; #2;
      check("R9 extest drives latched cells", {core_din, pin_dout}, 2'b10);
    end
    check("R9 extest words", {bus_ctl, apin_ctl}, {4'b1000, 4'b0010, 4'b0100});

    // R3 unknown opcode acts as bypass
    shift_ir(8'h5A, ic);
    check("R3 unknown opcode bypass_sel", {bypass_sel, test_mode}, 2'b10);
    scan_dr(14'h0F0F, dc);
    check("R3 unknown opcode scan", dc, {13'h0F0F, 1'b0});
    check("R3 unknown keeps latches", {bus_ctl, apin_ctl}, {4'b1000, 4'b0010, 4'b0100});

    // R1 five TMS-high cycles
    for (int i = 0; i < 5; i++) tick(1, 0, s, e);
    #1;
    check("R1 tms reset latches", {bus_ctl, apin_ctl}, 0);
    check("R1 tms reset bypass", bypass_sel, 1);
    tick(0, 0, s, e);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule